// File: doc/BRIEF.md
# SPI Flash Page-Size Configuration Sequencer

This block is a host-side SPI master that runs one of two operations on a serial flash when asked. The identification operation opens a chip-select frame and sends the read-ID opcode. It then clocks in a fixed number of reply bytes and presents each one on a byte output with a one-cycle valid strobe.

The configuration operation makes the flash's one-time page-size register select 256-byte pages. It sends the four-byte program command in a single frame and raises chip select directly after the last bit, which starts the flash's self-timed program cycle. After a minimum chip-select idle time it opens a second frame and reads status bytes continuously until the ready flag appears. If the page-size flag in that status byte is set, the result tells the host that a power cycle is now needed. If the flag is clear, the result asks the host to send the command again. When ready never appears within a parameterised number of status bytes, the operation ends with a timeout result.

The host sets `op_cfg`, pulses `start` and waits for the single-cycle `done` strobe, then reads `result`.

Top module: `spi_pagecfg_seq`

## Requirements
- R1: The identification operation sends opcode 0x9F most significant bit first inside one frame, then clocks in ID_BYTES bytes, presents each on `id_byte` with a one-cycle `id_valid` pulse in arrival order, closes the frame, and finishes with result 0.
- R2: The configuration operation sends exactly the bytes 0x3D, 0x2A, 0x80, 0xA6 in that order in one frame of exactly 32 SCK pulses. Chip select rises on the same clock edge as the final falling SCK edge.
- R3: SPI mode 0: SCK idles low and stays low whenever `cs_n` is high, MOSI never changes while SCK is high, and MISO is sampled on the rising SCK edge. One SCK half period lasts CLK_DIV system clocks.
- R4: After the configuration frame a status frame opens with opcode 0xD7. Status bytes are read one after another in that frame until a byte with bit 7 = 1 (ready) arrives, and that byte ends the frame.
- R5: If the ready status byte has bit 0 = 1, the result is 1 (binary page size set, power cycle required).
- R6: If the ready status byte has bit 0 = 0, the result is 2 (command must be reissued).
- R7: If POLL_LIMIT status bytes arrive without bit 7 set, the frame closes after the last of them and the result is 3 (timeout).
- R8: Between any two frames `cs_n` stays high for exactly CS_IDLE system clocks, and `done` is asserted exactly CS_IDLE clocks after the final chip-select rise of an operation.
- R9: `done` is a one-cycle pulse, `busy` is high from the cycle after an accepted `start` until `done`, and a `start` seen while `busy` is high has no effect.
- R10: After reset `cs_n` = 1, `sck` = 0, `busy` = 0, `done` = 0 and `result` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken only when idle |
| op_cfg | input | 1 | 0 = identification read, 1 = page-size configuration |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 2 | 0 ok, 1 power cycle required, 2 reissue, 3 timeout |
| id_byte | output | 8 | Identification byte |
| id_valid | output | 1 | One-cycle strobe for `id_byte` |
| cs_n | output | 1 | SPI chip select, active low |
| sck | output | 1 | SPI serial clock |
| mosi | output | 1 | SPI data to the flash |
| miso | input | 1 | SPI data from the flash |

## Verification
Each SCK half period takes CLK_DIV clocks, so a byte lasts 16·CLK_DIV clocks. A frame's length is due as 8 SCK pulses per byte sent or received, and the bench checks that pulse count exactly for each frame. `done` is due exactly CS_IDLE clocks after the final chip-select rise, and the gap between the configuration frame and the status frame has that same length. The bench samples every output on the falling system-clock edge and stamps each chip-select edge and each `done` with a cycle counter, so these delays are compared as exact differences. Identification bytes and results are compared only after the `done` strobe.

// File: rtl/spi_pagecfg_seq.sv
module spi_pagecfg_seq #(
  parameter int CLK_DIV    = 2,
  parameter int ID_BYTES   = 4,
  parameter int CS_IDLE    = 4,
  parameter int POLL_LIMIT = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       op_cfg,
  output logic       busy,
  output logic       done,
  output logic [1:0] result,
  output logic [7:0] id_byte,
  output logic       id_valid,
  output logic       cs_n,
  output logic       sck,
  output logic       mosi,
  input  logic       miso
);
  localparam int CW = $clog2(CLK_DIV + 1);
  localparam int BW = $clog2(ID_BYTES + POLL_LIMIT + 2);
  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam int GW = $clog2(CS_IDLE + 1);
  localparam logic [1:0] RES_OK = 2'd0, RES_PWR = 2'd1, RES_AGAIN = 2'd2, RES_TMO = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_GAP} st_t;
  typedef enum logic [1:0] {PH_ID, PH_CFG, PH_POLL} ph_t;

  st_t           st;
  ph_t           ph;
  logic [CW-1:0] cnt;
  logic [2:0]    bitcnt;
  logic [BW-1:0] bytecnt;
  logic [PW-1:0] polls;
  logic [GW-1:0] gap;
  logic [7:0]    tx, rx;
  logic          tick, byte_end, last;

  function automatic logic [7:0] cfg_byte(input logic [1:0] i);
    case (i)
      2'd0: cfg_byte = 8'h3D;
      2'd1: cfg_byte = 8'h2A;
      2'd2: cfg_byte = 8'h80;
      default: cfg_byte = 8'hA6;
    endcase
  endfunction

  assign busy     = (st != S_IDLE);
  assign mosi     = tx[7];
  assign tick     = (st == S_XFER) && (cnt == CW'(CLK_DIV - 1));
  assign byte_end = tick && sck && (bitcnt == 3'd7);

  always_comb begin
    case (ph)
      PH_ID:   last = (bytecnt == BW'(ID_BYTES));
      PH_CFG:  last = (bytecnt == BW'(3));
      default: last = (bytecnt != '0) && (rx[7] || polls == PW'(POLL_LIMIT - 1));
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= PH_ID; cnt <= '0; bitcnt <= '0; bytecnt <= '0;
      polls <= '0; gap <= '0; tx <= '0; rx <= '0; cs_n <= 1'b1; sck <= 1'b0;
      done <= 1'b0; result <= RES_OK; id_byte <= '0; id_valid <= 1'b0;
    end else begin
      done <= 1'b0;
      id_valid <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          ph <= op_cfg ? PH_CFG : PH_ID;
          tx <= op_cfg ? 8'h3D : 8'h9F;
          result <= RES_OK;
          cs_n <= 1'b0; cnt <= '0; bitcnt <= '0; bytecnt <= '0; polls <= '0;
          st <= S_XFER;
        end
        S_XFER: if (!tick) cnt <= cnt + 1'b1;
        else begin
          cnt <= '0;
          if (!sck) begin
            sck <= 1'b1;
            rx <= {rx[6:0], miso};
          end else begin
            sck <= 1'b0;
            if (bitcnt != 3'd7) begin
              bitcnt <= bitcnt + 1'b1;
              tx <= {tx[6:0], 1'b0};
            end else begin
              bitcnt <= '0;
              bytecnt <= bytecnt + 1'b1;
              tx <= (ph == PH_CFG && !last) ? cfg_byte(bytecnt[1:0] + 2'd1) : 8'h00;
              if (ph == PH_ID && bytecnt != '0) begin
                id_byte <= rx;
                id_valid <= 1'b1;
              end
              if (ph == PH_POLL && bytecnt != '0) begin
                if (rx[7]) result <= rx[0] ? RES_PWR : RES_AGAIN;
                else if (last) result <= RES_TMO;
                else polls <= polls + 1'b1;
              end
              if (last) begin
                cs_n <= 1'b1;
                gap <= '0;
                st <= S_GAP;
              end
            end
          end
        end
        default: if (gap == GW'(CS_IDLE - 1)) begin
          if (ph == PH_CFG) begin
            ph <= PH_POLL; tx <= 8'hD7; cs_n <= 1'b0;
            cnt <= '0; bitcnt <= '0; bytecnt <= '0; polls <= '0;
            st <= S_XFER;
          end else begin
            st <= S_IDLE;
            done <= 1'b1;
          end
        end else gap <= gap + 1'b1;
      endcase
    end
  end

  logic [GW-1:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) hi_cnt <= GW'(CS_IDLE);
    else if (!cs_n) hi_cnt <= '0;
    else if (hi_cnt != GW'(CS_IDLE)) hi_cnt <= hi_cnt + 1'b1;
  end

  assert_cs_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> hi_cnt == GW'(CS_IDLE));
  assert_sck_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  assert_mosi_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && cs_n));
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> busy);
endmodule

// File: tb/spi_pagecfg_seq_test.sv
module spi_pagecfg_seq_test;
  localparam int CLK_DIV = 2, ID_BYTES = 4, CS_IDLE = 4, POLL_LIMIT = 8;

  logic clk = 0, rst_n = 0, start = 0, op_cfg = 0, miso = 0;
  logic busy, done, id_valid, cs_n, sck, mosi;
  logic [1:0] result;
  logic [7:0] id_byte;

  spi_pagecfg_seq #(.CLK_DIV(CLK_DIV), .ID_BYTES(ID_BYTES), .CS_IDLE(CS_IDLE),
                    .POLL_LIMIT(POLL_LIMIT)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_cfg(op_cfg), .busy(busy), .done(done),
    .result(result), .id_byte(id_byte), .id_valid(id_valid), .cs_n(cs_n), .sck(sck),
    .mosi(mosi), .miso(miso));

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int busy_n = 0;
  logic [7:0] ready_val = 8'h81;

  function automatic logic [7:0] id_val(input int i);
    return 8'h1F + 8'(i * 8'h31);
  endfunction

  logic [7:0] fbytes [0:7][0:15];
  int fbits [0:7];
  int frames = 0, nb = 0;
  logic [7:0] sh = 0, ob = 0;
  logic s_cs = 1, s_sck = 0;

  function automatic logic [7:0] resp(input int k, input logic [7:0] opc);
    if (k == 0) return 8'h00;
    if (opc == 8'h9F) return id_val(k - 1);
    if (opc == 8'hD7) return (k - 1 < busy_n) ? 8'h01 : ready_val;
    return 8'h00;
  endfunction

  always @(cs_n or sck) begin
    if (cs_n !== s_cs) begin
      if (!cs_n) begin nb = 0; ob = 8'h00; miso = ob[7]; end
      else begin fbits[frames % 8] = nb; frames = frames + 1; end
      s_cs = cs_n;
    end
    if (sck !== s_sck) begin
      if (!cs_n) begin
        if (sck) begin
          sh = {sh[6:0], mosi};
          nb = nb + 1;
          if (nb % 8 == 0) fbytes[frames % 8][(nb / 8 - 1) % 16] = sh;
        end else begin
          if (nb % 8 == 0) ob = resp(nb / 8, fbytes[frames % 8][0]);
          else ob = {ob[6:0], 1'b0};
          miso = ob[7];
        end
      end
      s_sck = sck;
    end
  end

  logic [7:0] id_got [0:15];
  int id_cnt = 0, done_cnt = 0, done_cyc = 0, last_rise = 0, last_gap = 0, viol = 0;
  logic [1:0] done_res = 0;
  logic m_cs = 1, m_sck = 0, m_mosi = 0, busy_at_done = 0;
  always @(negedge clk) begin
    if (id_valid) begin id_got[id_cnt % 16] = id_byte; id_cnt = id_cnt + 1; end
    if (done) begin
      done_cnt = done_cnt + 1; done_res = result; done_cyc = cyc;
      if (busy) busy_at_done = 1;
    end
    if (cs_n && !m_cs) last_rise = cyc;
    if (!cs_n && m_cs) last_gap = cyc - last_rise;
    if (rst_n && !cs_n && sck && m_sck && mosi !== m_mosi) viol = viol + 1;
    if (rst_n && cs_n && sck) viol = viol + 1;
    m_cs = cs_n; m_sck = sck; m_mosi = mosi;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic op);
    int n = done_cnt;
    @(negedge clk); start = 1; op_cfg = op;
    @(negedge clk); start = 0;
    chk(busy === 1'b1, "R9 busy after start", busy, 1);
    for (int i = 0; i < 20000 && done_cnt == n; i++) @(negedge clk);
    chk(done_cnt == n + 1, "R9 one done per operation", done_cnt - n, 1);
    chk(done_cyc - last_rise == CS_IDLE, "R8 done delay after CS rise", done_cyc - last_rise, CS_IDLE);
  endtask

  task automatic test_reset;
    chk(cs_n === 1 && sck === 0, "R10 SPI idle in reset", {cs_n, sck}, 2);
    chk(busy === 0 && done === 0 && result === 0, "R10 status in reset", {busy, done, result}, 0);
  endtask

  task automatic test_id;
    int base = frames, ib = id_cnt;
    run_op(1'b0);
    chk(frames - base == 1, "R1 single frame", frames - base, 1);
    chk(fbytes[base % 8][0] == 8'h9F, "R1 opcode", fbytes[base % 8][0], 8'h9F);
    chk(fbits[base % 8] == 8 * (ID_BYTES + 1), "R1 frame length", fbits[base % 8], 8 * (ID_BYTES + 1));
    chk(id_cnt - ib == ID_BYTES, "R1 id strobe count", id_cnt - ib, ID_BYTES);
    for (int i = 0; i < ID_BYTES; i++)
      chk(id_got[(ib + i) % 16] == id_val(i), "R1 id byte", id_got[(ib + i) % 16], id_val(i));
    chk(done_res == 0, "R1 result", done_res, 0);
  endtask

  task automatic test_cfg(input int nbusy, input logic [7:0] rdy, input int exp_res, input string req);
    int base = frames;
    logic [7:0] seq [4] = '{8'h3D, 8'h2A, 8'h80, 8'hA6};
    busy_n = nbusy; ready_val = rdy;
    run_op(1'b1);
    chk(frames - base == 2, "R2 two frames", frames - base, 2);
    for (int i = 0; i < 4; i++)
      chk(fbytes[base % 8][i] == seq[i], "R2 command byte", fbytes[base % 8][i], seq[i]);
    chk(fbits[base % 8] == 32, "R2 command length", fbits[base % 8], 32);
    chk(fbytes[(base + 1) % 8][0] == 8'hD7, "R4 status opcode", fbytes[(base + 1) % 8][0], 8'hD7);
    chk(fbits[(base + 1) % 8] == 8 * (nbusy + 2), "R4 status bytes read",
        fbits[(base + 1) % 8], 8 * (nbusy + 2));
    chk(last_gap == CS_IDLE, "R8 gap between frames", last_gap, CS_IDLE);
    chk(done_res == 2'(exp_res), req, done_res, exp_res);
  endtask

  task automatic test_timeout;
    int base = frames;
    busy_n = 1000;
    run_op(1'b1);
    chk(fbits[(base + 1) % 8] == 8 * (POLL_LIMIT + 1), "R7 status bytes before timeout",
        fbits[(base + 1) % 8], 8 * (POLL_LIMIT + 1));
    chk(done_res == 3, "R7 timeout result", done_res, 3);
    chk(cs_n === 1, "R7 CS released", cs_n, 1);
  endtask

  task automatic test_ignore;
    int base = frames, n = done_cnt;
    @(negedge clk); start = 1; op_cfg = 0;
    @(negedge clk); start = 0;
    repeat (20) @(negedge clk);
    start = 1; op_cfg = 1;
    @(negedge clk); start = 0;
    for (int i = 0; i < 20000 && done_cnt == n; i++) @(negedge clk);
    repeat (2 * CS_IDLE + 40) @(negedge clk);
    chk(frames - base == 1, "R9 start while busy ignored", frames - base, 1);
    chk(done_res == 0 && !busy, "R9 result of first op kept", {busy, done_res}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset;
    rst_n = 1;
    @(negedge clk);
    test_reset;
    test_id;
    test_cfg(3, 8'h81, 1, "R5 power cycle result");
    test_cfg(0, 8'h80, 2, "R6 reissue result");
    test_cfg(1, 8'h8F, 1, "R5 power cycle result, other bits set");
    test_timeout;
    test_ignore;
    chk(viol == 0, "R3 mode 0 line discipline", viol, 0);
    chk(busy_at_done == 0, "R9 busy low at done", busy_at_done, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule